// File: doc/BRIEF.md
# Soft-Sector Track Byte Formatter

This block produces the byte sequence that is written to one track of a soft-sectored disc. An index pulse starts a track. The block answers it with a leading run of zero bytes and then a skip-defect record. That record carries three 16-bit defect addresses and their checksum. Each later sector pulse starts a sector record: a zero gap, an identification field, a second zero gap and a data field. Every field carries a sync byte, a CRC and zero fill. Once a record ends, zero bytes follow until the next pulse.

Payload bytes for the data field come from a buffer read port with a ready/valid handshake. The output strobe drops for any cycle in which the buffer has no byte ready. The head, cylinder, sector number and size code are captured at the sector pulse that starts a record. The defect addresses are captured at the index pulse. A downstream serialiser takes one byte for each cycle in which the strobe is high.

Top module: `trk_fmt`

## Requirements
- R1: After reset and before the first index pulse, `out_valid` and `pay_ready` stay low, and sector pulses do nothing.
- R2: An index pulse starts a defect record. It is 23 zero bytes, then sync byte FBh, then the three defect addresses, then a 2-byte checksum (high byte first), then two zero bytes. Address k is `defect_addrs[16k+15:16k]`. Address 0 goes first and each address sends its high byte first.
- R3: The defect checksum is the sum modulo 65536 of the six address bytes, each byte taken as an unsigned number.
- R4: After a record finishes, the block emits zero bytes with `out_valid` high on every cycle until the next accepted pulse.
- R5: A sector pulse accepted while idle emits a sector record. It begins with 23 zero bytes and then an ID field of nine bytes: F9h, {0, head[2:0], cyl[11:8]}, cyl[7:0], {0, sector[6:0]}, {000000, size[1:0]}, two CRC bytes, and two zero bytes.
- R6: Each CRC is CRC-16 with polynomial 1021h, preset FFFFh and MSB-first processing. It covers the field's sync byte through its last ID or payload byte, and it is sent high byte first. The CRC restarts for every field.
- R7: After the ID field come 11 zero bytes, then FDh, then 128 << size payload bytes, then two CRC bytes and two zero bytes.
- R8: `pay_ready` is high only while payload bytes are due. A payload byte is taken on a clock edge where `pay_valid` and `pay_ready` are both high, and it appears on `out_byte` in that same cycle. While `pay_valid` is low during the payload, `out_valid` is low and no byte is skipped.
- R9: An index pulse restarts the track with a defect record at any point in any record, and it wins over a sector pulse in the same cycle.
- R10: A sector pulse that arrives while a record is still being emitted, or before the first index, is ignored.
- R11: Head, cylinder, sector and size are held from the accepting pulse to the end of the record, so input changes during a record have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| index_pulse | input | 1 | One-cycle track start pulse |
| sector_pulse | input | 1 | One-cycle sector start pulse |
| head_in | input | 3 | Head number for the ID field |
| cyl_in | input | 12 | Cylinder number for the ID field |
| sect_in | input | 7 | Sector number for the ID field |
| size_code | input | 2 | Payload size, 128 << code bytes |
| defect_addrs | input | 48 | Three 16-bit defect addresses, address 0 in the low bits |
| pay_data | input | 8 | Payload byte from the buffer |
| pay_valid | input | 1 | Payload byte available |
| pay_ready | output | 1 | Block accepts a payload byte |
| out_byte | output | 8 | Emitted track byte |
| out_valid | output | 1 | `out_byte` is emitted this cycle |

## Verification
The assertions check on every cycle the rules that hold regardless of data. An index pulse always restarts at the first gap byte. A sector pulse cannot start a record unless the block is idle. The sync byte always leads into payload byte zero. Captured fields stay put through a record, the CRC register takes its preset in the gaps, and `pay_ready` is never high outside the payload. Only the bench scenarios can show that the byte values are right: the checksum and CRC contents, the field layout for each size code, stalls in the payload, a restart in the middle of a payload, and pulses that arrive during a record.

// File: rtl/trk_fmt_pkg.sv
// Shared constants, phase type and CRC step for the track byte formatter.
// Assumes fixed field layouts; only gap and payload lengths are tunable.
package trk_fmt_pkg;

    localparam int HEAD_W     = 3;
    localparam int CYL_W      = 12;
    localparam int SECT_W     = 7;
    localparam int SIZE_W     = 2;
    localparam int NUM_DEFECT = 3;
    localparam int DEFECT_W   = NUM_DEFECT * 16;
    localparam int DEFECT_LEN = 2 * NUM_DEFECT + 5;   // sync + addrs + sum(2) + fill(2)
    localparam int ID_LEN     = 9;                    // sync + 4 + crc(2) + fill(2)
    localparam int ID_CRC_POS = 5;                    // first CRC byte of the ID field
    localparam int TAIL_LEN   = 4;                    // crc(2) + fill(2)

    localparam logic [7:0]  SYNC_DEFECT = 8'hFB;
    localparam logic [7:0]  SYNC_ID     = 8'hF9;
    localparam logic [7:0]  SYNC_DATA   = 8'hFD;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;

    typedef enum logic [3:0] {
        PH_OFF, PH_GAP1, PH_DEFECT, PH_ID, PH_GAP2,
        PH_DSYNC, PH_DPAY, PH_DTAIL, PH_FILL
    } phase_e;

    // Advance a CRC-16 by one byte, MSB first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int b = 0; b < 8; b++)
            r = r[15] ? ((r << 1) ^ CRC_POLY) : (r << 1);
        return r;
    endfunction

endpackage

// File: rtl/trk_fmt_crc.sv
// CRC-16 accumulator. Loads the preset when asked and otherwise
// folds in one byte per advance. Assumes preset and advance never coincide.
module trk_fmt_crc
    import trk_fmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        preset,
    input  logic        advance,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    // Accumulator register.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc <= CRC_PRESET;
        else if (preset)  crc <= CRC_PRESET;
        else if (advance) crc <= crc16_byte(crc, din);
    end

    // R6: a preset cycle leaves the register at FFFFh
    a_r6_preset_load: assert property (@(posedge clk) disable iff (!rst_n)
        preset |=> (crc == CRC_PRESET));

endmodule

// File: rtl/trk_fmt_seq.sv
// Record sequencer: phase and byte counter, pulse acceptance and field capture.
// Assumes pulses are one cycle wide. Index wins over sector. A sector pulse is
// accepted only in the idle fill phase.
module trk_fmt_seq
    import trk_fmt_pkg::*;
#(
    parameter int GAP1_LEN  = 23,
    parameter int GAP2_LEN  = 11,
    parameter int BASE_SIZE = 128,
    parameter int CW        = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                index_pulse,
    input  logic                sector_pulse,
    input  logic                pay_fire,
    input  logic [HEAD_W-1:0]   head_in,
    input  logic [CYL_W-1:0]    cyl_in,
    input  logic [SECT_W-1:0]   sect_in,
    input  logic [SIZE_W-1:0]   size_in,
    input  logic [DEFECT_W-1:0] defect_in,
    output phase_e              phase,
    output logic [CW-1:0]       cnt,
    output logic [HEAD_W-1:0]   head_q,
    output logic [CYL_W-1:0]    cyl_q,
    output logic [SECT_W-1:0]   sect_q,
    output logic [SIZE_W-1:0]   size_q,
    output logic [DEFECT_W-1:0] defect_q
);

    phase_e        ph_nx;
    logic [CW-1:0] cnt_nx;
    logic          rec_defect;
    logic [CW:0]   pay_len;

    assign pay_len = (CW+1)'(BASE_SIZE) << size_q;

    // Next phase and count when no pulse overrides.
    always_comb begin
        ph_nx  = phase;
        cnt_nx = cnt;
        unique case (phase)
            PH_GAP1: if (cnt == CW'(GAP1_LEN-1)) begin
                         ph_nx = rec_defect ? PH_DEFECT : PH_ID; cnt_nx = '0;
                     end else cnt_nx = cnt + 1'b1;
            PH_DEFECT: if (cnt == CW'(DEFECT_LEN-1)) begin
                         ph_nx = PH_FILL; cnt_nx = '0;
                     end else cnt_nx = cnt + 1'b1;
            PH_ID:   if (cnt == CW'(ID_LEN-1)) begin
                         ph_nx = PH_GAP2; cnt_nx = '0;
                     end else cnt_nx = cnt + 1'b1;
            PH_GAP2: if (cnt == CW'(GAP2_LEN-1)) begin
                         ph_nx = PH_DSYNC; cnt_nx = '0;
                     end else cnt_nx = cnt + 1'b1;
            PH_DSYNC: begin ph_nx = PH_DPAY; cnt_nx = '0; end
            PH_DPAY: if (pay_fire) begin
                         if ({1'b0, cnt} == pay_len - 1'b1) begin
                             ph_nx = PH_DTAIL; cnt_nx = '0;
                         end else cnt_nx = cnt + 1'b1;
                     end
            PH_DTAIL: if (cnt == CW'(TAIL_LEN-1)) begin
                         ph_nx = PH_FILL; cnt_nx = '0;
                     end else cnt_nx = cnt + 1'b1;
            default: ;
        endcase
    end

    // State register with pulse acceptance and field capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_OFF; cnt <= '0; rec_defect <= 1'b0;
            head_q <= '0; cyl_q <= '0; sect_q <= '0; size_q <= '0; defect_q <= '0;
        end else if (index_pulse) begin
            phase <= PH_GAP1; cnt <= '0; rec_defect <= 1'b1;
            defect_q <= defect_in;
        end else if (sector_pulse && phase == PH_FILL) begin
            phase <= PH_GAP1; cnt <= '0; rec_defect <= 1'b0;
            head_q <= head_in; cyl_q <= cyl_in; sect_q <= sect_in; size_q <= size_in;
        end else begin
            phase <= ph_nx; cnt <= cnt_nx;
        end
    end

    // R9: index always restarts at the first gap byte
    a_r9_index_restart: assert property (@(posedge clk) disable iff (!rst_n)
        index_pulse |=> (phase == PH_GAP1 && cnt == '0));
    // R10: no record start unless idle or indexed
    a_r10_busy_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!index_pulse && phase != PH_FILL) |=> !(phase == PH_GAP1 && cnt == '0));
    // R7: the data sync byte leads straight into payload byte zero
    a_r7_sync_to_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DSYNC && !index_pulse) |=> (phase == PH_DPAY && cnt == '0));
    // R11: captured fields hold while a record runs
    a_r11_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FILL && !index_pulse) |=>
        ($stable(head_q) && $stable(cyl_q) && $stable(sect_q) && $stable(size_q)));

endmodule

// File: rtl/trk_fmt_mux.sv
// Byte selector: maps phase and count to the emitted byte and strobe,
// the payload ready, and the CRC control. Purely combinational.
module trk_fmt_mux
    import trk_fmt_pkg::*;
#(
    parameter int CW = 10
) (
    input  phase_e              phase,
    input  logic [CW-1:0]       cnt,
    input  logic [HEAD_W-1:0]   head_q,
    input  logic [CYL_W-1:0]    cyl_q,
    input  logic [SECT_W-1:0]   sect_q,
    input  logic [SIZE_W-1:0]   size_q,
    input  logic [DEFECT_W-1:0] defect_q,
    input  logic [15:0]         crc,
    input  logic [7:0]          pay_data,
    input  logic                pay_valid,
    output logic [7:0]          byte_out,
    output logic                byte_vld,
    output logic                pay_ready,
    output logic                crc_preset,
    output logic                crc_adv
);

    localparam int NB = 2 * NUM_DEFECT;

    logic [7:0]  dbyte [NB];
    logic [15:0] dsum;

    // Split the defect addresses into bytes, high byte first, and sum them.
    always_comb begin
        dsum = '0;
        for (int k = 0; k < NUM_DEFECT; k++) begin
            dbyte[2*k]   = defect_q[16*k+8 +: 8];
            dbyte[2*k+1] = defect_q[16*k   +: 8];
        end
        for (int k = 0; k < NB; k++) dsum = dsum + 16'(dbyte[k]);
    end

    // Byte and strobe per phase.
    always_comb begin
        byte_out  = 8'h00;
        byte_vld  = 1'b1;
        pay_ready = 1'b0;
        unique case (phase)
            PH_OFF: byte_vld = 1'b0;
            PH_DEFECT: begin
                if (cnt == '0)                    byte_out = SYNC_DEFECT;
                else if (int'(cnt) <= NB)         byte_out = dbyte[int'(cnt) - 1];
                else if (int'(cnt) == NB + 1)     byte_out = dsum[15:8];
                else if (int'(cnt) == NB + 2)     byte_out = dsum[7:0];
            end
            PH_ID: begin
                unique case (int'(cnt))
                    0: byte_out = SYNC_ID;
                    1: byte_out = {1'b0, head_q, cyl_q[11:8]};
                    2: byte_out = cyl_q[7:0];
                    3: byte_out = {1'b0, sect_q};
                    4: byte_out = {6'b0, size_q};
                    5: byte_out = crc[15:8];
                    6: byte_out = crc[7:0];
                    default: byte_out = 8'h00;
                endcase
            end
            PH_DSYNC: byte_out = SYNC_DATA;
            PH_DPAY: begin
                byte_out  = pay_data;
                byte_vld  = pay_valid;
                pay_ready = 1'b1;
            end
            PH_DTAIL: begin
                if (cnt == '0)      byte_out = crc[15:8];
                else if (cnt == 1)  byte_out = crc[7:0];
            end
            default: ;
        endcase
    end

    // CRC control: restart in gaps, fold ID bytes, data sync and payload.
    always_comb begin
        crc_preset = (phase == PH_GAP1) || (phase == PH_GAP2);
        crc_adv    = (phase == PH_ID && int'(cnt) < ID_CRC_POS) || (phase == PH_DSYNC)
                  || (phase == PH_DPAY && pay_valid);
    end

endmodule

// File: rtl/trk_fmt.sv
// Track byte formatter top: joins sequencer, byte selector and CRC unit.
// Assumes the downstream sink takes every byte whose strobe is high.
module trk_fmt
    import trk_fmt_pkg::*;
#(
    parameter int GAP1_LEN  = 23,
    parameter int GAP2_LEN  = 11,
    parameter int BASE_SIZE = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        index_pulse,
    input  logic        sector_pulse,
    input  logic [2:0]  head_in,
    input  logic [11:0] cyl_in,
    input  logic [6:0]  sect_in,
    input  logic [1:0]  size_code,
    input  logic [47:0] defect_addrs,
    input  logic [7:0]  pay_data,
    input  logic        pay_valid,
    output logic        pay_ready,
    output logic [7:0]  out_byte,
    output logic        out_valid
);

    localparam int CW = $clog2(BASE_SIZE) + 3;

    phase_e              phase;
    logic [CW-1:0]       cnt;
    logic [HEAD_W-1:0]   head_q;
    logic [CYL_W-1:0]    cyl_q;
    logic [SECT_W-1:0]   sect_q;
    logic [SIZE_W-1:0]   size_q;
    logic [DEFECT_W-1:0] defect_q;
    logic [15:0]         crc;
    logic                crc_preset, crc_adv;

    trk_fmt_seq #(.GAP1_LEN(GAP1_LEN), .GAP2_LEN(GAP2_LEN), .BASE_SIZE(BASE_SIZE), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .index_pulse(index_pulse), .sector_pulse(sector_pulse),
        .pay_fire(pay_valid && pay_ready),
        .head_in(head_in), .cyl_in(cyl_in), .sect_in(sect_in), .size_in(size_code),
        .defect_in(defect_addrs),
        .phase(phase), .cnt(cnt), .head_q(head_q), .cyl_q(cyl_q), .sect_q(sect_q),
        .size_q(size_q), .defect_q(defect_q)
    );

    trk_fmt_mux #(.CW(CW)) u_mux (
        .phase(phase), .cnt(cnt), .head_q(head_q), .cyl_q(cyl_q), .sect_q(sect_q),
        .size_q(size_q), .defect_q(defect_q), .crc(crc), .pay_data(pay_data),
        .pay_valid(pay_valid), .byte_out(out_byte), .byte_vld(out_valid),
        .pay_ready(pay_ready), .crc_preset(crc_preset), .crc_adv(crc_adv)
    );

    trk_fmt_crc u_crc (
        .clk(clk), .rst_n(rst_n), .preset(crc_preset), .advance(crc_adv),
        .din(out_byte), .crc(crc)
    );

    // R4: the cycle after the last tail byte is a valid zero byte
    a_r4_tail_to_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DTAIL && cnt == CW'(TAIL_LEN-1) && !index_pulse)
        |=> (out_valid && out_byte == 8'h00));
    // R8: the buffer is read only while payload is due
    a_r8_ready_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> (phase == PH_DPAY));
    // R1: nothing leaves the block before the first index
    a_r1_quiet_before_index: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_OFF) |-> (!out_valid && !pay_ready));

endmodule

// File: tb/trk_fmt_tb.sv
// Bench for trk_fmt: a behavioural queue of expected bytes, built at each
// accepted pulse and compared against the ports on every falling edge.
module trk_fmt_tb;

    typedef struct {
        logic [7:0] v;
        bit         pay;
        int         tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        index_pulse = 1'b0, sector_pulse = 1'b0;
    logic [2:0]  head_in = '0;
    logic [11:0] cyl_in = '0;
    logic [6:0]  sect_in = '0;
    logic [1:0]  size_code = '0;
    logic [47:0] defect_addrs = '0;
    logic [7:0]  pay_data;
    logic        pay_valid = 1'b1;
    logic        pay_ready, out_valid;
    logic [7:0]  out_byte;

    item_t q[$];
    int    pay_k = 0;
    bit    started = 0, do_pop = 0, stall_mode = 0;
    int    id_tag = 5, fill_tag = 4, gap_tag = 2;
    int    n_cmp = 0, n_bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;   // 250 MHz

    function automatic logic [7:0] pay_fn(input int k);
        return 8'((k * 37 + 11) & 255);
    endfunction
    assign pay_data = pay_fn(pay_k);

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        int r;
        r = int'(c) ^ (int'(d) << 8);
        for (int i = 0; i < 8; i++) begin
            r = r << 1;
            if (r & 32'h10000) r = r ^ 32'h11021;
        end
        return 16'(r);
    endfunction

    trk_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .index_pulse(index_pulse), .sector_pulse(sector_pulse),
        .head_in(head_in), .cyl_in(cyl_in), .sect_in(sect_in), .size_code(size_code),
        .defect_addrs(defect_addrs), .pay_data(pay_data), .pay_valid(pay_valid),
        .pay_ready(pay_ready), .out_byte(out_byte), .out_valid(out_valid)
    );

    task automatic push(input logic [7:0] v, input bit p, input int tag);
        item_t it;
        it.v = v; it.pay = p; it.tag = tag;
        q.push_back(it);
    endtask

    // R2 / R3 expected defect record.
    task automatic build_defect();
        int sum = 0;
        for (int i = 0; i < 23; i++) push(8'h00, 0, gap_tag);
        push(8'hFB, 0, 2);
        for (int a = 0; a < 3; a++) begin
            push(defect_addrs[16*a+8 +: 8], 0, 2);
            push(defect_addrs[16*a +: 8], 0, 2);
            sum = sum + int'(defect_addrs[16*a+8 +: 8]) + int'(defect_addrs[16*a +: 8]);
        end
        push(8'((sum >> 8) & 255), 0, 3);   // R3
        push(8'(sum & 255), 0, 3);
        push(8'h00, 0, 2); push(8'h00, 0, 2);
    endtask

    // R5 / R6 / R7 / R8 expected sector record.
    task automatic build_sector();
        logic [15:0] c;
        logic [7:0]  idb [5];
        int n;
        for (int i = 0; i < 23; i++) push(8'h00, 0, 5);
        idb[0] = 8'hF9;
        idb[1] = {1'b0, head_in, cyl_in[11:8]};
        idb[2] = cyl_in[7:0];
        idb[3] = {1'b0, sect_in};
        idb[4] = {6'd0, size_code};
        c = 16'hFFFF;
        for (int i = 0; i < 5; i++) begin push(idb[i], 0, id_tag); c = ref_crc(c, idb[i]); end
        push(c[15:8], 0, 6); push(c[7:0], 0, 6);
        push(8'h00, 0, 5); push(8'h00, 0, 5);
        for (int i = 0; i < 11; i++) push(8'h00, 0, 7);
        c = ref_crc(16'hFFFF, 8'hFD);
        push(8'hFD, 0, 7);
        n = 128 << size_code;
        for (int i = 0; i < n; i++) begin
            push(pay_fn(pay_k + i), 1, 8);
            c = ref_crc(c, pay_fn(pay_k + i));
        end
        push(c[15:8], 0, 6); push(c[7:0], 0, 6);
        push(8'h00, 0, 7); push(8'h00, 0, 7);
    endtask

    // Compare ports against the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [7:0] eb; logic ev, er; int tag; bit bad;
            bad = 0;
            if (q.size() == 0) begin
                ev = started; er = 1'b0; eb = 8'h00; tag = started ? fill_tag : 1;
                do_pop = 0;
            end else if (q[0].pay) begin
                ev = pay_valid; er = 1'b1; eb = q[0].v; tag = q[0].tag; do_pop = pay_valid;
            end else begin
                ev = 1'b1; er = 1'b0; eb = q[0].v; tag = q[0].tag; do_pop = 1;
            end
            n_cmp++;
            if (out_valid !== ev) begin
                $display("FAIL R%0d out_valid actual %b expected %b", tag, out_valid, ev); bad = 1;
            end
            if (pay_ready !== er) begin
                $display("FAIL R8 pay_ready actual %b expected %b", pay_ready, er); bad = 1;
            end
            if (ev && out_byte !== eb) begin
                $display("FAIL R%0d out_byte actual %h expected %h", tag, out_byte, eb); bad = 1;
            end
            if (bad) n_bad++;
        end
    end

    // Model update at the active edge: pop, then accept pulses.
    always @(posedge clk) begin
        bit was_empty;
        was_empty = (q.size() == 0);
        if (!rst_n) begin
            q.delete(); started = 0;
        end else begin
            if (do_pop && q.size() != 0) begin
                if (q[0].pay) pay_k <= pay_k + 1;
                void'(q.pop_front());
            end
            if (index_pulse) begin
                q.delete(); build_defect(); started = 1;      // R9
            end else if (sector_pulse && started && was_empty) begin
                build_sector();
            end
        end
        do_pop = 0;
    end

    // Payload availability pattern.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        pay_valid = stall_mode ? !(lfsr[0] & lfsr[1]) : 1'b1;
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_idx();
        @(posedge clk); #1 index_pulse = 1'b1;
        @(posedge clk); #1 index_pulse = 1'b0;
    endtask

    task automatic pulse_sec();
        @(posedge clk); #1 sector_pulse = 1'b1;
        @(posedge clk); #1 sector_pulse = 1'b0;
    endtask

    task automatic wait_done();
        while (q.size() != 0) @(posedge clk);
        tick(4);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(5);                                  // R1: quiet after reset
        pulse_sec();                              // R10 / R1: no index yet
        tick(4);

        defect_addrs = {16'h0102, 16'hF0E1, 16'hFFFF};
        gap_tag = 2;
        pulse_idx();                              // R2, R3
        wait_done();                              // R4 fill

        head_in = 3'd5; cyl_in = 12'hA53; sect_in = 7'd17; size_code = 2'd0;
        pulse_sec();                              // R5, R6, R7
        wait_done();

        stall_mode = 1; id_tag = 11; fill_tag = 10;
        head_in = 3'd2; cyl_in = 12'h0FF; sect_in = 7'd99; size_code = 2'd1;
        pulse_sec();                              // R8 stalls
        head_in = 3'd7; cyl_in = 12'h123; sect_in = 7'd1; size_code = 2'd3;  // R11
        tick(40);
        pulse_sec();                              // R10: busy, ignored
        wait_done();
        id_tag = 5; fill_tag = 4;

        head_in = 3'd1; cyl_in = 12'hFFF; sect_in = 7'd127; size_code = 2'd2;
        pulse_sec();
        wait_done();

        stall_mode = 0;
        size_code = 2'd3; sect_in = 7'd0; cyl_in = 12'h000; head_in = 3'd0;
        pulse_sec();
        wait_done();

        stall_mode = 1;
        size_code = 2'd1;
        pulse_sec();
        tick(80);                                 // inside the payload
        defect_addrs = {16'h8000, 16'h7FFF, 16'h0001};
        gap_tag = 9;
        pulse_idx();                              // R9 restart mid-record
        wait_done();

        @(posedge clk); #1 index_pulse = 1'b1; sector_pulse = 1'b1;   // R9 priority
        @(posedge clk); #1 index_pulse = 1'b0; sector_pulse = 1'b0;
        wait_done();
        tick(5);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule